// File: doc/BRIEF.md
# Video Processor CPU Port Interface

This block connects an 8-bit CPU to the internal memories of a video processor through two byte-wide ports picked by one address bit. The control port is written twice in a row. The first write fills the low half of an internal 14-bit address pointer. The second write fills the upper six address bits and a 2-bit command that chooses between four operations. The first operation is a video RAM read, which fetches one byte ahead. The second is a video RAM write. The third loads a control register. The fourth is a colour RAM write. A flag records which half of the pair comes next. Any data-port access or status read clears that flag.

Data-port reads do not return the byte at the pointer. They return a one-byte read-ahead buffer, and then reload that buffer from video RAM at the pointer. Every data access moves the pointer forward by one and wraps at 14 bits. Data writes go to colour RAM or video RAM, as the command selects, and also leave the written byte in the buffer. A status read on the control port returns the frame-interrupt flag and two sticky event flags. It then clears them, together with the line-interrupt flag, and so drops the CPU interrupt line. The memories sit outside the block behind simple synchronous ports with one cycle of read latency.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset the pointer, the pending flag, the command, the read-ahead buffer, all 16 registers, `cpu_rdata` and `cpu_irq` are zero. The first data read therefore returns 0x00 from pointer 0, and a status read returns 0x00.
- R2: A control write with the pending flag clear replaces pointer bits 7:0 with the written byte, keeps pointer bits 13:8, and sets the pending flag. It issues no memory or register access.
- R3: A control write with the pending flag set loads pointer bits 13:8 from data bits 5:0 and the command from data bits 7:6, then clears the pending flag. The command codes are 0 = video RAM read, 1 = video RAM write, 2 = register load and 3 = colour RAM write. Codes 1 and 3 start no memory read.
- R4: A second control write with code 2 gives a one-cycle `reg_we` pulse, with `reg_idx` equal to data bits 3:0 and `reg_wdata` equal to pointer bits 7:0.
- R5: A second control write with code 0 starts a video RAM read at the new pointer in the same cycle. The fetched byte fills the buffer, and the pointer becomes the new pointer plus one.
- R6: A data read returns the buffer contents one cycle after the strobe. It starts a video RAM read at the current pointer to refill the buffer, moves the pointer forward by one with 0x3FFF wrapping to 0x0000, and clears the pending flag. Back-to-back reads return consecutive bytes.
- R7: A data write goes to colour RAM at pointer bits 4:0 when the command is 3, and to video RAM at the pointer otherwise, never to both. It moves the pointer forward by one, copies the byte into the buffer and clears the pending flag.
- R8: A status read returns bit 7 = frame-interrupt flag, bit 6 = `evt_set[1]` sticky flag and bit 5 = `evt_set[0]` sticky flag. It clears all three flags, the line-interrupt flag and the pending flag, so `cpu_irq` is low in the following cycle.
- R9: Status bits 4:0 read as 1 when register 0 bit 2 is set, and as 0 otherwise.
- R10: `cpu_irq` is high exactly when the frame flag is set with register 1 bit 5 set, or the line flag is set with register 0 bit 4 set. Enabling an interrupt while its flag is already pending raises the line.
- R11: An interrupt or event pulse that arrives in the same cycle as a status read is not lost. The read returns the older value, and the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Port select: 0 data, 1 control |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe (wins over `cpu_rd`) |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte, registered on the strobe cycle |
| cpu_irq | output | 1 | CPU interrupt request |
| frame_evt | input | 1 | Frame interrupt event pulse |
| line_evt | input | 1 | Line interrupt event pulse |
| evt_set | input | 2 | Sticky status event pulses (bit 1 to status 6, bit 0 to status 5) |
| vram_addr | output | 14 | Video RAM address |
| vram_rd_en | output | 1 | Video RAM read enable, data one cycle later |
| vram_rdata | input | 8 | Video RAM read data |
| vram_we | output | 1 | Video RAM write enable |
| vram_wdata | output | 8 | Video RAM write data |
| cram_we | output | 1 | Colour RAM write enable |
| cram_addr | output | 5 | Colour RAM address |
| cram_wdata | output | 8 | Colour RAM write data |
| reg_we | output | 1 | Register load strobe |
| reg_idx | output | 4 | Register number being loaded |
| reg_wdata | output | 8 | Register load value |

## Verification
Memory and register strobes (`vram_rd_en`, `vram_we`, `cram_we`, `reg_we` and their address and data) are combinational in the strobe cycle. They are sampled 1 ns after the inputs change, while the strobe is still high. `cpu_rdata` is due one cycle after a read strobe. A driver queues the expected byte, and a monitor that tracks the strobe across the clock edge compares it at the next falling edge. This also covers a buffer refill that is still in flight when the next read comes. `cpu_irq` follows its flags one cycle after an event pulse or status read, and is sampled at the falling edge after that pulse.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;
  localparam int ADDR_W = 14;
  localparam int BYTE_W = 8;
  localparam int CRAM_AW = 5;
  localparam int REG_N = 16;
  localparam int REG_IW = $clog2(REG_N);
  localparam int EVT_W = 2;
  localparam int LOW_STAT_W = BYTE_W - 1 - EVT_W;

  typedef enum logic [1:0] {
    CMD_VRAM_RD = 2'd0,
    CMD_VRAM_WR = 2'd1,
    CMD_REG_LD  = 2'd2,
    CMD_CRAM_WR = 2'd3
  } cmd_e;

  // pointer advance with natural wrap at ADDR_W bits
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  // status byte: frame flag, sticky events, constant filler bits
  function automatic logic [BYTE_W-1:0] status_byte(input logic frame,
                                                    input logic [EVT_W-1:0] evts,
                                                    input logic fill_ones);
    return {frame, evts, {LOW_STAT_W{fill_ones}}};
  endfunction
endpackage

// File: rtl/vdp_addr_latch.sv
module vdp_addr_latch
  import vdp_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          data_acc,
  input  logic          stat_rd,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] ptr_q,
  output cmd_e          cmd_q,
  output logic          pend_q,
  output logic          first_wr,
  output logic          second_wr,
  output logic [AW-1:0] second_ptr,
  output cmd_e          second_cmd
);
  localparam int HI_W = AW - 8;

  always_comb begin
    first_wr   = ctl_wr && !pend_q;
    second_wr  = ctl_wr && pend_q;
    second_ptr = {wdata[HI_W-1:0], ptr_q[7:0]};
    second_cmd = cmd_e'(wdata[7:6]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cmd_q  <= CMD_VRAM_RD;
      pend_q <= 1'b0;
    end else if (first_wr) begin
      ptr_q  <= {ptr_q[AW-1:8], wdata};
      pend_q <= 1'b1;
    end else if (second_wr) begin
      cmd_q  <= second_cmd;
      pend_q <= 1'b0;
      ptr_q  <= (second_cmd == CMD_VRAM_RD) ? ptr_next(second_ptr) : second_ptr;
    end else if (data_acc) begin
      ptr_q  <= ptr_next(ptr_q);
      pend_q <= 1'b0;
    end else if (stat_rd) begin
      pend_q <= 1'b0;
    end
  end

  AST_FIRST_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> pend_q); // R2
  AST_FIRST_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> ptr_q[AW-1:8] == $past(ptr_q[AW-1:8])); // R2
  AST_SECOND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    second_wr |=> !pend_q); // R3
  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc || stat_rd) && !ctl_wr |=> !pend_q); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !ctl_wr && (ptr_q == '1) |=> ptr_q == '0); // R6
endmodule

// File: rtl/vdp_read_buffer.sv
module vdp_read_buffer
  import vdp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_req,
  input  logic              wr_copy,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] vram_rdata,
  output logic [BYTE_W-1:0] buf_q,
  output logic              fill_pend,
  output logic [BYTE_W-1:0] buf_view
);
  // a refill issued last cycle has its byte on vram_rdata now
  always_comb buf_view = fill_pend ? vram_rdata : buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      fill_pend <= 1'b0;
    end else begin
      fill_pend <= fill_req && !wr_copy;
      if (wr_copy)        buf_q <= wdata;
      else if (fill_pend) buf_q <= vram_rdata;
    end
  end

  AST_COPY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_copy |=> buf_q == $past(wdata)); // R7
  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend && !wr_copy |=> buf_q == $past(vram_rdata)); // R6
  AST_REFILL_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !wr_copy |=> fill_pend); // R5
endmodule

// File: rtl/vdp_status_irq.sv
module vdp_status_irq
  import vdp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              frame_evt,
  input  logic              line_evt,
  input  logic [EVT_W-1:0]  evt_set,
  input  logic              frame_ie,
  input  logic              line_ie,
  input  logic              fill_ones,
  output logic [BYTE_W-1:0] stat_view,
  output logic              irq
);
  logic             frame_q;
  logic             line_q;
  logic [EVT_W-1:0] evts_q;

  always_comb begin
    stat_view = status_byte(frame_q, evts_q, fill_ones);
    irq       = (frame_q && frame_ie) || (line_q && line_ie);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      line_q  <= 1'b0;
      evts_q  <= '0;
    end else if (stat_rd) begin
      frame_q <= frame_evt;
      line_q  <= line_evt;
      evts_q  <= evt_set;
    end else begin
      frame_q <= frame_q | frame_evt;
      line_q  <= line_q | line_evt;
      evts_q  <= evts_q | evt_set;
    end
  end

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !frame_evt && !line_evt |=> !irq); // R8
  AST_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> frame_q); // R11
  AST_LINE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt |=> line_q); // R11
endmodule

// File: rtl/vdp_reg_file.sv
module vdp_reg_file
  import vdp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [REG_IW-1:0] idx,
  input  logic [BYTE_W-1:0] val,
  output logic [BYTE_W-1:0] reg0,
  output logic [BYTE_W-1:0] reg1
);
  logic [BYTE_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                        regs[g] <= '0;
      else if (ld && idx == REG_IW'(g))  regs[g] <= val;
    end
  end

  always_comb begin
    reg0 = regs[0];
    reg1 = regs[1];
  end

  AST_REG_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    ld && idx == '0 |=> reg0 == $past(val)); // R4
endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
  import vdp_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [BYTE_W-1:0]  cpu_wdata,
  output logic [BYTE_W-1:0]  cpu_rdata,
  output logic               cpu_irq,
  input  logic               frame_evt,
  input  logic               line_evt,
  input  logic [EVT_W-1:0]   evt_set,
  output logic [ADDR_W-1:0]  vram_addr,
  output logic               vram_rd_en,
  input  logic [BYTE_W-1:0]  vram_rdata,
  output logic               vram_we,
  output logic [BYTE_W-1:0]  vram_wdata,
  output logic               cram_we,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic [BYTE_W-1:0]  cram_wdata,
  output logic               reg_we,
  output logic [REG_IW-1:0]  reg_idx,
  output logic [BYTE_W-1:0]  reg_wdata
);
  // decoded one-cycle events
  logic ctl_wr, data_wr, data_rd, stat_rd;
  logic first_wr, second_wr, prefetch;
  logic [ADDR_W-1:0] ptr_q, second_ptr;
  cmd_e cmd_q, second_cmd;
  logic pend_q;
  logic [BYTE_W-1:0] buf_q, buf_view, stat_view, reg0, reg1;
  logic fill_pend;

  always_comb begin
    ctl_wr  = cpu_wr && cpu_sel;
    data_wr = cpu_wr && !cpu_sel;
    data_rd = cpu_rd && !cpu_wr && !cpu_sel;
    stat_rd = cpu_rd && !cpu_wr && cpu_sel;
  end

  vdp_addr_latch #(.AW(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_acc(data_rd || data_wr),
    .stat_rd(stat_rd), .wdata(cpu_wdata), .ptr_q(ptr_q), .cmd_q(cmd_q),
    .pend_q(pend_q), .first_wr(first_wr), .second_wr(second_wr),
    .second_ptr(second_ptr), .second_cmd(second_cmd)
  );

  always_comb begin
    prefetch   = second_wr && (second_cmd == CMD_VRAM_RD);
    vram_rd_en = data_rd || prefetch;
    vram_addr  = prefetch ? second_ptr : ptr_q;
    vram_we    = data_wr && (cmd_q != CMD_CRAM_WR);
    vram_wdata = cpu_wdata;
    cram_we    = data_wr && (cmd_q == CMD_CRAM_WR);
    cram_addr  = ptr_q[CRAM_AW-1:0];
    cram_wdata = cpu_wdata;
    reg_we     = second_wr && (second_cmd == CMD_REG_LD);
    reg_idx    = cpu_wdata[REG_IW-1:0];
    reg_wdata  = ptr_q[7:0];
  end

  vdp_read_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .fill_req(vram_rd_en), .wr_copy(data_wr),
    .wdata(cpu_wdata), .vram_rdata(vram_rdata), .buf_q(buf_q),
    .fill_pend(fill_pend), .buf_view(buf_view)
  );

  vdp_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .ld(reg_we), .idx(reg_idx), .val(reg_wdata),
    .reg0(reg0), .reg1(reg1)
  );

  vdp_status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .frame_evt(frame_evt),
    .line_evt(line_evt), .evt_set(evt_set), .frame_ie(reg1[5]),
    .line_ie(reg0[4]), .fill_ones(reg0[2]), .stat_view(stat_view), .irq(cpu_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       cpu_rdata <= '0;
    else if (data_rd) cpu_rdata <= buf_view;
    else if (stat_rd) cpu_rdata <= stat_view;
  end

  AST_ONE_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_we && cram_we)); // R7
  AST_REG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4
  AST_NO_RD_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd_en |-> !vram_we); // R5
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |-> !vram_rd_en && !reg_we && !vram_we && !cram_we); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_rd) |-> $stable(cpu_rdata)); // R6
endmodule

// File: tb/vdp_cpu_port_test.sv
`timescale 1ns/1ps
module vdp_cpu_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic cpu_irq;
  logic frame_evt = 1'b0, line_evt = 1'b0;
  logic [1:0] evt_set = '0;
  logic [13:0] vram_addr;
  logic vram_rd_en, vram_we, cram_we, reg_we;
  logic [7:0] vram_rdata = '0;
  logic [7:0] vram_wdata, cram_wdata, reg_wdata;
  logic [4:0] cram_addr;
  logic [3:0] reg_idx;

  int n_run = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string req_q[$];
  logic rd_seen = 1'b0;
  logic [7:0] vmem [int];

  always #5 clk = ~clk;

  vdp_cpu_port uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq),
    .frame_evt(frame_evt), .line_evt(line_evt), .evt_set(evt_set),
    .vram_addr(vram_addr), .vram_rd_en(vram_rd_en), .vram_rdata(vram_rdata),
    .vram_we(vram_we), .vram_wdata(vram_wdata), .cram_we(cram_we),
    .cram_addr(cram_addr), .cram_wdata(cram_wdata), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata)
  );

  function automatic logic [7:0] seed(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  function automatic logic [7:0] vlook(input logic [13:0] a);
    if (vmem.exists(int'(a))) return vmem[int'(a)];
    return seed(a);
  endfunction

  // video RAM model: one cycle read latency
  always @(posedge clk) begin
    if (vram_we) vmem[int'(vram_addr)] = vram_wdata;
    if (vram_rd_en) vram_rdata <= vlook(vram_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: read data due one cycle after the strobe
  always @(posedge clk) rd_seen <= cpu_rd && !cpu_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("scoreboard", 32'hdead, 32'h0);
      else chk(req_q.pop_front(), {24'h0, cpu_rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic go(input logic s, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    #1;
  endtask

  task automatic stop();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] d);
    go(1'b1, 1'b0, 1'b1, d); stop();
  endtask

  task automatic read_start(input logic s, input logic [7:0] exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    go(s, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic status(input logic [7:0] exp, input string req);
    read_start(1'b1, exp, req); stop();
  endtask

  task automatic pulse_evt(input logic f, input logic l, input logic [1:0] e);
    @(negedge clk); frame_evt = f; line_evt = l; evt_set = e;
    @(negedge clk); frame_evt = 1'b0; line_evt = 1'b0; evt_set = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", cpu_rdata, 0);
    chk("R1 irq", cpu_irq, 0);
    status(8'h00, "R1 status");
    read_start(1'b0, 8'h00, "R1 buffer");
    chk("R1 ptr", vram_addr, 14'h0000);
    chk("R6 refill", vram_rd_en, 1);
    stop();
    // pointer is 0x0001 now
    go(1'b1, 1'b0, 1'b1, 8'h34);
    chk("R2 quiet", {vram_rd_en, reg_we, vram_we, cram_we}, 0);
    stop();
    go(1'b1, 1'b0, 1'b1, 8'h12);
    chk("R5 prefetch en", vram_rd_en, 1);
    chk("R5 prefetch addr", vram_addr, 14'h1234);
    stop();
    read_start(1'b0, seed(14'h1234), "R5 prefetched");
    chk("R6 ptr inc", vram_addr, 14'h1235);
    stop();
    read_start(1'b0, seed(14'h1235), "R6 next");
    stop();
    read_start(1'b0, seed(14'h1236), "R6 back-to-back");
    stop();
    // register 0 <- 0x04 (pointer becomes 0x0004)
    ctl(8'h04);
    go(1'b1, 1'b0, 1'b1, 8'h80);
    chk("R4 strobe", reg_we, 1);
    chk("R4 idx", reg_idx, 0);
    chk("R4 val", reg_wdata, 8'h04);
    chk("R3 no read code2", vram_rd_en, 0);
    stop();
    chk("R4 one pulse", reg_we, 0);
    status(8'h1F, "R9 ones");
    // half control pair, then data read clears pending
    ctl(8'hAA);
    read_start(1'b0, seed(14'h1237), "R6 buffer kept");
    chk("R2 low loaded", vram_addr, 14'h00AA);
    stop();
    ctl(8'hFF);
    go(1'b1, 1'b0, 1'b1, 8'h7F);
    chk("R3 no read code1", vram_rd_en, 0);
    stop();
    go(1'b0, 1'b0, 1'b1, 8'h99);
    chk("R7 vram we", {vram_we, cram_we}, 2'b10);
    chk("R3 upper loaded", vram_addr, 14'h3FFF);
    stop();
    read_start(1'b0, 8'h99, "R7 copy to buffer");
    chk("R6 wrap", vram_addr, 14'h0000);
    stop();
    read_start(1'b0, seed(14'h0000), "R6 after wrap");
    stop();
    // upper bits kept by a lone first write
    ctl(8'h00); ctl(8'h6A);
    ctl(8'h77);
    go(1'b0, 1'b0, 1'b1, 8'h5A);
    chk("R2 upper kept", vram_addr, 14'h2A77);
    stop();
    ctl(8'h11); ctl(8'h6A);
    go(1'b0, 1'b0, 1'b1, 8'h01);
    chk("R7 pending cleared", vram_addr, 14'h2A11);
    stop();
    // colour RAM
    ctl(8'h25); ctl(8'hC0);
    go(1'b0, 1'b0, 1'b1, 8'h3C);
    chk("R7 cram sel", {vram_we, cram_we}, 2'b01);
    chk("R7 cram addr", cram_addr, 5'd5);
    chk("R7 cram data", cram_wdata, 8'h3C);
    stop();
    go(1'b0, 1'b0, 1'b1, 8'h3D);
    chk("R7 cram inc", cram_addr, 5'd6);
    stop();
    // interrupts: register 1 <- 0x20
    ctl(8'h20); ctl(8'h81);
    chk("R10 idle", cpu_irq, 0);
    pulse_evt(1'b1, 1'b0, 2'b00);
    chk("R10 frame irq", cpu_irq, 1);
    status(8'h9F, "R8 frame bit");
    chk("R8 irq drop", cpu_irq, 0);
    pulse_evt(1'b0, 1'b1, 2'b00);
    chk("R10 line masked", cpu_irq, 0);
    ctl(8'h14); ctl(8'h80);
    chk("R10 late enable", cpu_irq, 1);
    status(8'h1F, "R8 line hidden");
    chk("R8 line cleared", cpu_irq, 0);
    pulse_evt(1'b0, 1'b0, 2'b11);
    status(8'h7F, "R8 sticky");
    status(8'h1F, "R8 cleared");
    ctl(8'h00); ctl(8'h80);
    status(8'h00, "R9 zeros");
    // event coinciding with status read
    read_start(1'b1, 8'h00, "R11 old value");
    frame_evt = 1'b1;
    stop();
    frame_evt = 1'b0;
    chk("R11 irq kept", cpu_irq, 1);
    status(8'h80, "R11 flag kept");
    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule